// File: doc/BRIEF.md
# Ticket lock unit

A shared mutual-exclusion manager for a fixed set of requesters. A requester that wants the lock raises its acquire line for one cycle. The unit hands it the next number from a ticket counter, and the counter moves on. The requester then waits. Each waiting slot compares its stored number against a single now-serving counter. When the two match, the slot becomes the holder and its grant line rises.

The holder raises its release line when it leaves the critical section. This advances now-serving, so the waiter holding the following number is granted next. Entry is therefore strictly first-come, first-served. No arbitration takes place among waiters on each attempt.

Several acquires in one cycle are ordered by requester index. A release from a requester that does not hold the lock changes nothing and raises a one-cycle error pulse.

Top module: `ticket_lock_unit`

## Requirements
- R1: After synchronous reset, `grant` is 0, `next_ticket` and `serving` are 0, `idle` is 1 and `rel_err` is 0.
- R2: An acquire pulse from a requester that is neither waiting nor holding stores the current `next_ticket` value as its ticket. `next_ticket` then increases by one on the following edge.
- R3: When several free requesters raise acquire in the same cycle, they take consecutive tickets with the lowest index taking the smallest. `next_ticket` advances by the number accepted.
- R4: A slot whose stored ticket equals `serving` raises its grant bit on the edge after that match is present. With the lock idle, this makes grant visible two edges after the acquire is sampled.
- R5: At most one bit of `grant` is high in any cycle.
- R6: A grant bit stays high until that requester raises its release line, and falls on the edge that samples the release.
- R7: A release from the current holder increases `serving` by one on the same edge. The waiter holding the next ticket is granted one edge later.
- R8: Requesters are granted in the order in which their acquires were accepted.
- R9: A release from a requester whose grant bit is low leaves `serving` and `grant` unchanged. On the next edge, `rel_err` goes high for exactly one cycle.
- R10: An acquire from a requester that is already waiting or holding is ignored and consumes no ticket.
- R11: Both counters are TW bits wide, with TW = clog2(N_REQ+1), and wrap modulo 2^TW.
- R12: `idle` is high exactly when `next_ticket` equals `serving`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | N_REQ | One-cycle acquire pulse per requester |
| rel_req | input | N_REQ | One-cycle release pulse per requester |
| grant | output | N_REQ | Lock held by the requester of that bit |
| next_ticket | output | TW | Number the next accepted acquire will receive |
| serving | output | TW | Now-serving counter |
| idle | output | 1 | No ticket outstanding |
| rel_err | output | 1 | Registered pulse for a release by a non-holder |

## Verification
Dispensing and serving can both move in the same cycle. The bench provokes this in two ways:
- A free requester acquires on the very edge where the holder releases.
- Acquires arrive on an idle lock, so the new ticket equals a `serving` value that is itself changing.

A behavioural reference model, built from per-requester states and two integer counters, predicts both counters, every grant bit, `idle` and `rel_err` for each cycle. The bench compares the outputs after every edge. The same holds for a stray release that coincides with a legitimate one. It must flag the error without disturbing the advance of `serving`.

// File: rtl/tkl_pkg.sv
package tkl_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_HOLD = 2'd2
    } slot_state_e;

    // Counter width: wide enough that every outstanding ticket is distinct
    // and a full queue is never mistaken for an idle lock.
    function automatic int tkt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tkl_dispenser.sv
module tkl_dispenser #(
    parameter int N_REQ = 4,
    parameter int TW    = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_REQ-1:0]          acq_req,
    input  logic [N_REQ-1:0]          slot_free,
    output logic [N_REQ-1:0]          accept,
    output logic [N_REQ-1:0][TW-1:0]  load_tkt,
    output logic [TW-1:0]             next_ticket
);

    logic [TW-1:0]            next_q;
    logic [N_REQ:0][TW-1:0]   cum;

    assign cum[0] = next_q;

    // Prefix count: lower index takes the smaller number.
    for (genvar i = 0; i < N_REQ; i++) begin : g_pfx
        assign accept[i]   = acq_req[i] & slot_free[i];
        assign load_tkt[i] = cum[i];
        assign cum[i+1]    = cum[i] + TW'(accept[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) next_q <= '0;
        else     next_q <= cum[N_REQ];
    end

    assign next_ticket = next_q;

endmodule

// File: rtl/tkl_slot.sv
module tkl_slot #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_tkt,
    input  logic [TW-1:0] serving,
    input  logic          rel,
    output logic          holds,
    output logic          is_free
);
    import tkl_pkg::*;

    slot_state_e   state_q;
    slot_state_e   state_d;
    logic [TW-1:0] tkt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (load)              state_d = SLOT_WAIT;
            SLOT_WAIT: if (tkt_q == serving)  state_d = SLOT_HOLD;
            SLOT_HOLD: if (rel)               state_d = SLOT_FREE;
            default:                          state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_FREE;
            tkt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load && state_q == SLOT_FREE) tkt_q <= load_tkt;
        end
    end

    assign holds   = (state_q == SLOT_HOLD);
    assign is_free = (state_q == SLOT_FREE);

endmodule

// File: rtl/tkl_release.sv
module tkl_release #(
    parameter int N_REQ = 4,
    parameter int TW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] rel_req,
    input  logic [N_REQ-1:0] holds,
    output logic [TW-1:0]    serving,
    output logic             rel_err
);

    logic [TW-1:0] serv_q;
    logic          err_q;
    logic          good_rel;
    logic          bad_rel;

    assign good_rel = |(rel_req & holds);
    assign bad_rel  = |(rel_req & ~holds);

    always_ff @(posedge clk) begin
        if (rst) begin
            serv_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (good_rel) serv_q <= serv_q + TW'(1);
            err_q <= bad_rel;
        end
    end

    assign serving = serv_q;
    assign rel_err = err_q;

endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
    parameter int N_REQ = 4,
    parameter int TW    = tkl_pkg::tkt_width(N_REQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] acq_req,
    input  logic [N_REQ-1:0] rel_req,
    output logic [N_REQ-1:0] grant,
    output logic [TW-1:0]    next_ticket,
    output logic [TW-1:0]    serving,
    output logic             idle,
    output logic             rel_err
);

    logic [N_REQ-1:0]          slot_free;
    logic [N_REQ-1:0]          accept;
    logic [N_REQ-1:0][TW-1:0]  load_tkt;
    logic [N_REQ-1:0]          holds;

    tkl_dispenser #(.N_REQ(N_REQ), .TW(TW)) u_disp (
        .clk         (clk),
        .rst         (rst),
        .acq_req     (acq_req),
        .slot_free   (slot_free),
        .accept      (accept),
        .load_tkt    (load_tkt),
        .next_ticket (next_ticket)
    );

    for (genvar i = 0; i < N_REQ; i++) begin : g_slot
        tkl_slot #(.TW(TW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (accept[i]),
            .load_tkt (load_tkt[i]),
            .serving  (serving),
            .rel      (rel_req[i]),
            .holds    (holds[i]),
            .is_free  (slot_free[i])
        );
    end

    tkl_release #(.N_REQ(N_REQ), .TW(TW)) u_rel (
        .clk     (clk),
        .rst     (rst),
        .rel_req (rel_req),
        .holds   (holds),
        .serving (serving),
        .rel_err (rel_err)
    );

    assign grant = holds;
    assign idle  = (next_ticket == serving);

endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
    parameter int N_REQ = 4,
    parameter int TW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [N_REQ-1:0] rel_req,
    input logic [N_REQ-1:0] grant,
    input logic [TW-1:0]    serving,
    input logic             idle,
    input logic             rel_err
);

    // R5
    single_holder_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R7
    serve_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (|(rel_req & grant)) |=> (serving == $past(serving) + TW'(1)));

    // R9
    serve_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(rel_req & grant)) |=> $stable(serving));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (|(rel_req & ~grant)) |=> rel_err);

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(rel_req & ~grant)) |=> !rel_err);

    // R12
    idle_free_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> (grant == '0));

    for (genvar i = 0; i < N_REQ; i++) begin : g_hold
        // R6
        grant_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (grant[i] && !rel_req[i]) |=> grant[i]);
        // R6
        grant_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (grant[i] && rel_req[i]) |=> !grant[i]);
    end

endmodule

bind ticket_lock_unit ticket_lock_chk #(.N_REQ(N_REQ), .TW(TW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rel_req (rel_req),
    .grant   (grant),
    .serving (serving),
    .idle    (idle),
    .rel_err (rel_err)
);

// File: tb/sim_ticket_lock_unit.sv
module sim_ticket_lock_unit;

    localparam int N  = 4;
    localparam int TW = 3;
    localparam int M  = 8;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0]  acq;
    logic [N-1:0]  rel;
    logic [N-1:0]  grant;
    logic [TW-1:0] next_ticket;
    logic [TW-1:0] serving;
    logic          idle;
    logic          rel_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model: 0 free, 1 waiting, 2 holding
    int m_st[N];
    int m_tk[N];
    int m_nt;
    int m_sv;
    int m_err;

    always #10 clk = ~clk;

    ticket_lock_unit #(.N_REQ(N)) u0 (
        .clk(clk), .rst(rst), .acq_req(acq), .rel_req(rel),
        .grant(grant), .next_ticket(next_ticket), .serving(serving),
        .idle(idle), .rel_err(rel_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0;
            m_tk[i] = 0;
        end
        m_nt = 0; m_sv = 0; m_err = 0;
    endtask

    task automatic model_step(input logic [N-1:0] a, input logic [N-1:0] r);
        int nst[N];
        int adv;
        int bad;
        adv = 0; bad = 0;
        for (int i = 0; i < N; i++) begin
            nst[i] = m_st[i];
            if (r[i] && m_st[i] != 2) bad = 1;
            if (m_st[i] == 0 && a[i]) begin
                m_tk[i] = m_nt;
                m_nt    = (m_nt + 1) % M;
                nst[i]  = 1;
            end else if (m_st[i] == 1 && m_tk[i] == m_sv) begin
                nst[i] = 2;
            end else if (m_st[i] == 2 && r[i]) begin
                nst[i] = 0;
                adv    = 1;
            end
        end
        for (int i = 0; i < N; i++) m_st[i] = nst[i];
        if (adv != 0) m_sv = (m_sv + 1) % M;
        m_err = bad;
    endtask

    function automatic logic [N-1:0] hold_mask();
        logic [N-1:0] h;
        for (int i = 0; i < N; i++) h[i] = (m_st[i] == 2);
        return h;
    endfunction

    task automatic compare();
        chk("R4 R5 R6 R7 R8 grant", int'(grant), int'(hold_mask()));
        chk("R2 R3 R10 R11 next_ticket", int'(next_ticket), m_nt);
        chk("R7 R9 R11 serving", int'(serving), m_sv);
        chk("R12 idle", int'(idle), (m_nt == m_sv) ? 1 : 0);
        chk("R9 rel_err", int'(rel_err), m_err);
    endtask

    task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
        acq = a;
        rel = r;
        @(posedge clk);
        model_step(a, r);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [N-1:0] a;
        logic [N-1:0] r;
        rst = 1'b1; acq = '0; rel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1 reset state
        chk("R1 grant", int'(grant), 0);
        chk("R1 next_ticket", int'(next_ticket), 0);
        chk("R1 serving", int'(serving), 0);
        chk("R1 idle", int'(idle), 1);
        chk("R1 rel_err", int'(rel_err), 0);

        // R4: single acquire on idle lock, grant two edges later
        step(4'b0100, '0);
        chk("R4 no grant yet", int'(grant), 0);
        step('0, '0);
        chk("R4 grant after match", int'(grant), 4'b0100);

        // R3: three simultaneous acquires
        step(4'b1011, '0);
        chk("R3 next_ticket", int'(next_ticket), 4);

        // R10: repeat acquire from waiting and holding requesters
        step(4'b0101, '0);
        chk("R10 no ticket consumed", int'(next_ticket), 4);

        // R9: stray release from a waiter
        step('0, 4'b0001);
        step('0, '0);

        // R7 R8: holder releases while a stray release coincides
        step('0, 4'b0110);
        step('0, '0);
        chk("R8 lowest index next", int'(grant), 4'b0001);

        // release and acquire in the same cycle
        step(4'b0100, 4'b0001);
        step('0, '0);
        chk("R8 second in line", int'(grant), 4'b0010);

        // mixed traffic
        for (int k = 0; k < 3000; k++) begin
            a = N'($urandom);
            r = hold_mask() & (($urandom % 3 == 0) ? '1 : '0);
            if ($urandom % 12 == 0) r = r | N'($urandom);
            step(a, r);
        end

        // drain
        for (int k = 0; k < 40; k++) step('0, hold_mask());
        chk("R12 drained idle", int'(idle), 1);

        finish_run();
    end

endmodule